// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filtering

This block receives asynchronous serial frames and, when several receivers share one line, decides which frames concern it. A frame begins with a low start bit and ends with a high stop bit. Between them come eight data bits, least significant first, and in nine-bit mode a ninth bit. The ninth bit marks an address frame when it is 1 and a data frame when it is 0. The line is sampled with a 16x oversampling tick, and each bit is read at the middle of its period.

Two registers give the receiver its identity. An address register holds the receiver's own address. A mask register selects which of its bits are compared with the received byte; bits with a 0 in the mask are ignored. A second, wider identity is formed as the bitwise OR of the two registers. A received byte matches it when the byte has a 1 in every position where the OR has a 1, so a byte of all ones reaches every receiver on the line. While the filter control is on, only address frames that pass one of these two tests update the outputs and raise the completion flag. Software clears the filter control after its address arrives so that the following data frames are also taken. The interrupt output mirrors the completion flag.

Top module: `uart9_addr_rx`

## Requirements
- R1: A frame is a low start bit, eight data bits with the least significant first, a ninth bit when `nine_bit` is 1, then a stop bit. Each bit is sampled at the middle of its period, counting 16 `os_tick` pulses per bit. An accepted frame puts the data bits on `rx_data` and the ninth bit on `rx_bit9`.
- R2: If the line is high again at the midpoint of the start bit, the pulse is treated as noise. The receiver returns to idle, the outputs do not change, and the next real frame is received normally.
- R3: A frame whose stop bit samples low is dropped. `rx_data`, `rx_bit9` and `rx_done` keep their values.
- R4: When `mp_en` is 0, every frame with a good stop bit is accepted, including data frames whose ninth bit is 0.
- R5: When `mp_en` is 1 in nine-bit mode, a frame whose ninth bit is 0 is ignored, and all outputs keep their values.
- R6: When `mp_en` is 1, an address frame (ninth bit 1) is accepted when `(byte XOR addr_reg) AND addr_mask` is zero. For example, address 0x35 with mask 0x0F accepts 0x25, and address 0x35 with mask 0xF3 accepts 0x31.
- R7: When `mp_en` is 1, an address frame is also accepted when `byte AND (addr_reg OR addr_mask)` equals `addr_reg OR addr_mask`. Under address 0x35 with mask 0x0F this accepts 0x3F and 0xFF. A byte of 0xFF is accepted under any settings.
- R8: When `mp_en` is 1, an address frame that passes neither test is ignored. Examples are 0x26 under 0x35/0x0F, and 0xF5 under 0x35/0xF3.
- R9: `rx_done` is set by an accepted frame and stays at 1 until a cycle in which `flag_clr` is 1. A new accepted frame in that same cycle keeps it at 1. `irq` always equals `rx_done`.
- R10: While reset is active, `rx_done`, `irq`, `rx_data` and `rx_bit9` are 0.
- R11: When `nine_bit` is 0, the frame carries eight data bits and no ninth bit, and it is always accepted whatever the value of `mp_en`. In this mode `rx_bit9` takes the value of the stop bit, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | Oversampling tick, 16 per bit period |
| nine_bit | input | 1 | 1 selects frames with a ninth bit |
| mp_en | input | 1 | 1 enables address filtering |
| addr_reg | input | 8 | Own slave address |
| addr_mask | input | 8 | Compare mask; 1 means the bit is checked |
| flag_clr | input | 1 | Clears the completion flag |
| rx_data | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_done | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request, equal to the flag |

## Verification
A falling edge on `ser_in` takes two clocks to pass the input synchronizer. The middle of the stop bit then comes about 9.5 bit periods later in eight-bit mode and 10.5 in nine-bit mode. The flag and data change two clocks after that midpoint tick: one register for the frame result and one for the output.

The monitor compares data at the falling clock edge after `rx_done` rises. The driver idles the line for 1.5 bit periods after each stop bit before it checks that every expected result has arrived. For a frame that should be ignored, the driver compares the outputs after that same idle time with the values they had before the frame.

// File: rtl/uart9_rx_pkg.sv
package uart9_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_t;

endpackage

// File: rtl/uart9_rx_sync.sv
module uart9_rx_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("uart9_rx_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= RESET_VAL;
         else        ff <= d;
      end
      assign q = ff;
   end else begin : g_chain
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= {STAGES{RESET_VAL}};
         else        ff <= {ff[STAGES-2:0], d};
      end
      assign q = ff[STAGES-1];
   end

endmodule

// File: rtl/uart9_rx_frame.sv
module uart9_rx_frame
   import uart9_rx_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic              os_tick,
   input  logic              nine_bit,
   output logic              frm_valid,
   output logic [DATA_W-1:0] frm_data,
   output logic              frm_bit9,
   output logic              frm_stop
);

   localparam int TW   = (OVS > 1) ? $clog2(OVS) : 1;
   localparam int HALF = OVS / 2;
   localparam int BW   = $clog2(DATA_W + 2);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("uart9_rx_frame: OVS must be even and at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("uart9_rx_frame: DATA_W must be at least 2");
   end

   rx_state_t         state;
   logic [TW-1:0]     tick_cnt;
   logic [BW-1:0]     bit_cnt;
   logic [DATA_W:0]   sh;
   logic              nine_q;
   logic              rxd_prev;
   logic              at_half;
   logic              at_full;
   logic              last_bit;

   assign at_half  = (tick_cnt == TW'(HALF - 1));
   assign at_full  = (tick_cnt == TW'(OVS - 1));
   assign last_bit = nine_q ? (bit_cnt == BW'(DATA_W)) : (bit_cnt == BW'(DATA_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         tick_cnt  <= '0;
         bit_cnt   <= '0;
         sh        <= '0;
         nine_q    <= 1'b0;
         rxd_prev  <= 1'b1;
         frm_valid <= 1'b0;
         frm_data  <= '0;
         frm_bit9  <= 1'b0;
         frm_stop  <= 1'b0;
      end else begin
         rxd_prev  <= rxd;
         frm_valid <= 1'b0;
         unique case (state)
            RX_IDLE: begin
               tick_cnt <= '0;
               bit_cnt  <= '0;
               if (!rxd && rxd_prev) begin
                  state  <= RX_START;
                  nine_q <= nine_bit;
               end
            end
            RX_START: begin
               if (os_tick) begin
                  if (at_half) begin
                     tick_cnt <= '0;
                     state    <= rxd ? RX_IDLE : RX_BITS;
                  end else begin
                     tick_cnt <= tick_cnt + 1'b1;
                  end
               end
            end
            RX_BITS: begin
               if (os_tick) begin
                  if (at_full) begin
                     tick_cnt <= '0;
                     sh       <= {rxd, sh[DATA_W:1]};
                     bit_cnt  <= bit_cnt + 1'b1;
                     if (last_bit) state <= RX_STOP;
                  end else begin
                     tick_cnt <= tick_cnt + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (os_tick) begin
                  if (at_full) begin
                     tick_cnt  <= '0;
                     frm_valid <= 1'b1;
                     frm_stop  <= rxd;
                     frm_data  <= nine_q ? sh[DATA_W-1:0] : sh[DATA_W:1];
                     frm_bit9  <= nine_q ? sh[DATA_W] : rxd;
                     state     <= RX_IDLE;
                  end else begin
                     tick_cnt <= tick_cnt + 1'b1;
                  end
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R2: a high line at the start-bit midpoint returns the receiver to idle
   a_r2_glitch_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_START && os_tick && at_half && rxd) |=> (state == RX_IDLE));

   // R1: a frame result lasts a single cycle
   a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> !frm_valid);

   // R1: a result is produced only on leaving the stop-bit state
   a_r1_valid_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frm_valid) |-> ($past(state) == RX_STOP));

endmodule

// File: rtl/uart9_rx_match.sv
module uart9_rx_match #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] byte_in,
   input  logic [DATA_W-1:0] own_addr,
   input  logic [DATA_W-1:0] own_mask,
   output logic              masked_hit,
   output logic              bcast_hit
);

   logic [DATA_W-1:0] m_ok;
   logic [DATA_W-1:0] b_ok;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic bc_bit;
      assign bc_bit  = own_addr[i] | own_mask[i];
      assign m_ok[i] = ~own_mask[i] | (byte_in[i] ~^ own_addr[i]);
      assign b_ok[i] = ~bc_bit | byte_in[i];
   end

   assign masked_hit = &m_ok;
   assign bcast_hit  = &b_ok;

   always_comb begin
      // R7: an all-ones byte reaches every receiver
      if (&byte_in) a_r7_all_ones_bcast: assert (bcast_hit);
      // R6: the own address always passes the masked test
      if (byte_in == own_addr) a_r6_own_addr_hits: assert (masked_hit);
   end

endmodule

// File: rtl/uart9_addr_rx.sv
module uart9_addr_rx
   import uart9_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_in,
   input  logic              os_tick,
   input  logic              nine_bit,
   input  logic              mp_en,
   input  logic [DATA_W-1:0] addr_reg,
   input  logic [DATA_W-1:0] addr_mask,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit9,
   output logic              rx_done,
   output logic              irq
);

   logic              rxd;
   logic              frm_valid;
   logic [DATA_W-1:0] frm_data;
   logic              frm_bit9;
   logic              frm_stop;
   logic              masked_hit;
   logic              bcast_hit;
   logic              filter_ok;
   logic              accept;

   uart9_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ser_in),
      .q     (rxd)
   );

   uart9_rx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .rxd       (rxd),
      .os_tick   (os_tick),
      .nine_bit  (nine_bit),
      .frm_valid (frm_valid),
      .frm_data  (frm_data),
      .frm_bit9  (frm_bit9),
      .frm_stop  (frm_stop)
   );

   uart9_rx_match #(.DATA_W(DATA_W)) u_match (
      .byte_in    (frm_data),
      .own_addr   (addr_reg),
      .own_mask   (addr_mask),
      .masked_hit (masked_hit),
      .bcast_hit  (bcast_hit)
   );

   assign filter_ok = !mp_en || !nine_bit || (frm_bit9 && (masked_hit || bcast_hit));
   assign accept    = frm_valid && frm_stop && filter_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_bit9 <= 1'b0;
         rx_done <= 1'b0;
      end else begin
         if (accept) begin
            rx_data <= frm_data;
            rx_bit9 <= frm_bit9;
            rx_done <= 1'b1;
         end else if (flag_clr) begin
            rx_done <= 1'b0;
         end
      end
   end

   assign irq = rx_done;

   // R3: a bad stop bit leaves the outputs alone
   a_r3_bad_stop_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !frm_stop) |=> ($stable(rx_data) && $stable(rx_bit9)));

   // R4: with the filter off, a good frame always sets the flag
   a_r4_open_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && frm_stop && !mp_en) |=> rx_done);

   // R5: data frames are ignored while filtering
   a_r5_data_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && mp_en && nine_bit && !frm_bit9) |=> ($stable(rx_data) && $stable(rx_bit9)));

   // R9: the flag holds until cleared
   a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !flag_clr) |=> rx_done);

   // R9: a clear without a new frame drops the flag
   a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !frm_valid) |=> !rx_done);

   // R9: the flag rises only after a frame result
   a_r9_rise_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_done) |-> $past(frm_valid));

endmodule

// File: tb/sim_uart9_addr_rx.sv
module sim_uart9_addr_rx;

   localparam int BIT_CLK = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_in = 1'b1;
   logic       os_tick = 1'b0;
   logic       nine_bit = 1'b1;
   logic       mp_en = 1'b0;
   logic [7:0] addr_reg = 8'h35;
   logic [7:0] addr_mask = 8'h0F;
   logic       flag_clr = 1'b0;
   logic [7:0] rx_data;
   logic       rx_bit9;
   logic       rx_done;
   logic       irq;

   int n_total = 0;
   int n_fail  = 0;
   string cur_req = "R1";
   logic [8:0] exp_q[$];

   always #10 clk = ~clk;

   always @(negedge clk) os_tick <= ~os_tick;

   uart9_addr_rx u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_in    (ser_in),
      .os_tick   (os_tick),
      .nine_bit  (nine_bit),
      .mp_en     (mp_en),
      .addr_reg  (addr_reg),
      .addr_mask (addr_mask),
      .flag_clr  (flag_clr),
      .rx_data   (rx_data),
      .rx_bit9   (rx_bit9),
      .rx_done   (rx_done),
      .irq       (irq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic drive_bit(input logic v);
      ser_in = v;
      repeat (BIT_CLK) @(negedge clk);
   endtask

   task automatic pulse_clr();
      @(negedge clk) flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
   endtask

   // Driver: sends one frame and records what the design should report.
   task automatic send_frame(input logic [7:0] b, input logic b9, input logic stopv,
                             input bit keep, input bit expect_acc, input string req);
      logic [7:0] pd;
      logic       p9;
      logic       pf;
      if (!keep) pulse_clr();
      cur_req = req;
      pd = rx_data;
      p9 = rx_bit9;
      pf = rx_done;
      if (expect_acc) exp_q.push_back({(nine_bit ? b9 : 1'b1), b});
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(b[i]);
      if (nine_bit) drive_bit(b9);
      drive_bit(stopv);
      ser_in = 1'b1;
      repeat (BIT_CLK + BIT_CLK / 2) @(negedge clk);
      chk(exp_q.size() == 0, req, "expected result not delivered", exp_q.size(), 0);
      if (!expect_acc) begin
         chk(rx_done == pf, req, "flag changed on ignored frame", rx_done, pf);
         chk(rx_data == pd, req, "data changed on ignored frame", rx_data, pd);
         chk(rx_bit9 == p9, req, "ninth bit changed on ignored frame", rx_bit9, p9);
      end
   endtask

   // Monitor: compares each flag rise against the scoreboard.
   initial begin
      @(posedge rst_n);
      forever begin
         @(posedge rx_done);
         @(negedge clk);
         if (exp_q.size() == 0) begin
            chk(1'b0, cur_req, "unexpected accept, data", rx_data, 0);
         end else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk(rx_data == e[7:0], cur_req, "data", rx_data, e[7:0]);
            chk(rx_bit9 == e[8], cur_req, "ninth bit", rx_bit9, e[8]);
            chk(irq == rx_done, "R9", "irq mirrors flag", irq, rx_done);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10: reset state
      chk(rx_done == 1'b0, "R10", "flag in reset", rx_done, 0);
      chk(irq == 1'b0, "R10", "irq in reset", irq, 0);
      chk(rx_data == 8'h00, "R10", "data in reset", rx_data, 0);
      chk(rx_bit9 == 1'b0, "R10", "ninth bit in reset", rx_bit9, 0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);

      // R4 / R1: filter off, data frame with ninth bit 0 accepted
      mp_en = 1'b0;
      send_frame(8'hA5, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
      send_frame(8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, "R1");

      // R5: filter on, data frame ignored
      mp_en = 1'b1;
      send_frame(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, "R5");

      // R6: masked hit under 0x35 / 0x0F
      send_frame(8'h25, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
      // R8: neither test passes
      send_frame(8'h26, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
      // R7: broadcast hits
      send_frame(8'h3F, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
      send_frame(8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
      send_frame(8'hF5, 1'b1, 1'b1, 1'b0, 1'b1, "R6");

      // Second configuration: 0x35 / 0xF3
      addr_mask = 8'hF3;
      send_frame(8'h31, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
      send_frame(8'hF5, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
      send_frame(8'hF7, 1'b1, 1'b1, 1'b0, 1'b1, "R7");

      // Third configuration: 0x35 / 0xC0, any address still takes 0xFF
      addr_mask = 8'hC0;
      send_frame(8'h15, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
      send_frame(8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
      addr_mask = 8'h0F;

      // R3: bad stop bit dropped even with the filter off
      mp_en = 1'b0;
      send_frame(8'h81, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
      send_frame(8'h42, 1'b0, 1'b1, 1'b0, 1'b1, "R3");

      // R2: short low pulse is noise
      pulse_clr();
      begin
         logic [7:0] pd;
         pd = rx_data;
         cur_req = "R2";
         ser_in = 1'b0;
         repeat (8) @(negedge clk);
         ser_in = 1'b1;
         repeat (3 * BIT_CLK) @(negedge clk);
         chk(rx_done == 1'b0, "R2", "flag after glitch", rx_done, 0);
         chk(rx_data == pd, "R2", "data after glitch", rx_data, pd);
      end
      send_frame(8'h99, 1'b1, 1'b1, 1'b0, 1'b1, "R2");

      // R9: flag persists across an ignored frame, then clears
      mp_en = 1'b1;
      send_frame(8'h05, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
      send_frame(8'h11, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
      chk(rx_done == 1'b1, "R9", "flag held", rx_done, 1);
      chk(irq == 1'b1, "R9", "irq held", irq, 1);
      @(negedge clk) flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
      chk(rx_done == 1'b0, "R9", "flag after clear", rx_done, 0);
      chk(irq == 1'b0, "R9", "irq after clear", irq, 0);
      chk(rx_data == 8'h05, "R9", "data kept after clear", rx_data, 8'h05);

      // R11: eight-bit mode bypasses the filter, ninth bit shows stop
      nine_bit = 1'b0;
      send_frame(8'h5A, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
      send_frame(8'hC3, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
      nine_bit = 1'b1;

      repeat (20) @(negedge clk);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule